// File: doc/BRIEF.md
# Task-Indexed Microengine State File

This block keeps a private copy of a microengine's working state for every task it can run, so the engine may change task on any microcycle without spending cycles on saving or restoring registers. Each kind of state (microcode program counter, branch condition bits, subroutine return link, memory data word and one scratch word) lives in a small fast memory with one entry per task.

A priority selector chooses the task for the coming microcycle and broadcasts its number one cycle early. The state memories are read at that address, so the selected task's state is presented in a register at the start of the cycle in which it runs. At the end of each cycle the datapath hands back the running task's updated state, and the block writes it into that task's entry. If the same task is chosen again, a bypass delivers the freshly written values instead of the stale memory contents.

Task 0 is the background task and may always be preempted. Any other task keeps the engine until it raises the block signal, which lets the selector pick the highest-numbered pending wakeup.

Top module: `task_state_file`

## Requirements
- R1: After reset `cur_task` is 0 and `cur_pc` is 0. The first time any task k is selected after reset, its presented program counter equals k, and its other state fields are 0.
- R2: `cur_task` in each cycle equals the value `next_task` had in the cycle before.
- R3: When a switch is allowed, `next_task` is the highest index k in 1..NTASK-1 with `wake_req[k]` set. If no such bit is set, `next_task` is 0.
- R4: While `cur_task` is nonzero and `task_block` is low, `next_task` equals `cur_task`, whatever `wake_req` holds.
- R5: While `cur_task` is 0, a switch is allowed, so any pending request in 1..NTASK-1 takes the engine in the next cycle.
- R6: In the cycle after a task is selected, the `cur_*` outputs show the values last written back for that task.
- R7: At every clock edge out of reset, the running task's entry in every state memory is replaced by the `upd_*` inputs. Entries of other tasks keep their values.
- R8: When the running task is selected again, the `cur_*` outputs in the next cycle equal the `upd_*` inputs of the cycle before.
- R9: `wake_req[0]` has no effect on task selection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wake_req | input | NTASK | Pending wakeup per task; bit 0 ignored |
| task_block | input | 1 | Running task gives up the engine |
| upd_pc | input | PCW | Updated program counter of running task |
| upd_cond | input | CW | Updated branch condition bits |
| upd_link | input | PCW | Updated subroutine return link |
| upd_mdr | input | DW | Updated memory data word |
| upd_tmp | input | DW | Updated scratch word |
| next_task | output | TW | Task selected for the coming cycle |
| cur_task | output | TW | Task running this cycle |
| cur_pc | output | PCW | Program counter of running task |
| cur_cond | output | CW | Branch condition bits of running task |
| cur_link | output | PCW | Return link of running task |
| cur_mdr | output | DW | Memory data word of running task |
| cur_tmp | output | DW | Scratch word of running task |

## Verification
The bench aims at back-to-back selection of the same task, where a design without the bypass would present the values from before the last write-back. It returns to tasks after other tasks have run, which exposes write-back into the wrong entry or a read address that is one cycle late. It raises requests while a foreground task holds the engine, which catches a selector that preempts without the block signal. It drives request bit 0 alone, and it wakes fresh tasks to confirm that each starts at its own index.

// File: rtl/tsf_pkg.sv
// Shared types for the task-indexed state file.
// Assumes nothing beyond the IEEE 1800-2017 language.
package tsf_pkg;
    // How a state bank fills its entries at reset.
    typedef enum logic {
        INIT_ZERO  = 1'b0,  // every entry cleared
        INIT_INDEX = 1'b1   // entry k loaded with k (start addresses)
    } init_mode_e;
endpackage

// File: rtl/tsf_arbiter.sv
// Priority task selector.
// Picks the task for the next microcycle. The running task keeps the engine
// unless it blocks or it is the background task 0. When a switch is allowed
// the highest-numbered pending request wins, and task 0 runs when none pend.
// Assumes cur_task < NTASK. Request bit 0 is never considered.
module tsf_arbiter #(
    parameter int NTASK = 16,
    localparam int TW = $clog2(NTASK)
) (
    input  logic [NTASK-1:0] req,
    input  logic             blk,
    input  logic [TW-1:0]    cur_task,
    output logic [TW-1:0]    next_task
);
    logic [TW-1:0] pick;
    logic          may_switch;

    // Highest set request above bit 0; later iterations override earlier.
    always_comb begin
        pick = '0;
        for (int k = 0; k < NTASK; k++) begin
            if (req[k] && (k != 0)) pick = TW'(k);
        end
    end

    // Background task is always preemptible, foreground only after blocking.
    always_comb begin
        may_switch = blk || (cur_task == '0);
        next_task  = may_switch ? pick : cur_task;
    end
endmodule

// File: rtl/tsf_bank.sv
// One kind of per-task state held as a small memory indexed by task number.
// Each clock edge the running task's entry takes the write data, and the
// output register loads the entry of the broadcast next task, bypassing the
// write data when the same task is read and written in one cycle.
// Assumes rd_idx and wr_idx are below NTASK.
module tsf_bank
    import tsf_pkg::*;
#(
    parameter int         NTASK = 16,
    parameter int         W     = 16,
    parameter init_mode_e INIT  = INIT_ZERO,
    localparam int TW = $clog2(NTASK)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] rd_idx,
    input  logic [TW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  rd_q
);
    logic [W-1:0] mem [NTASK];

    for (genvar k = 0; k < NTASK; k++) begin : g_entry
        localparam logic [W-1:0] RST_VAL = (INIT == INIT_INDEX) ? W'(k) : '0;

        // Entry k: reset to its start value, then take write-back when running.
        always_ff @(posedge clk) begin
            if (!rst_n)                  mem[k] <= RST_VAL;
            else if (wr_idx == TW'(k))   mem[k] <= wr_data;
        end
    end

    // Output register: next task's entry, or the bypass on a repeat.
    always_ff @(posedge clk) begin
        if (!rst_n)                  rd_q <= '0;
        else if (rd_idx == wr_idx)   rd_q <= wr_data;
        else                         rd_q <= mem[rd_idx];
    end
endmodule

// File: rtl/task_state_file.sv
// Task-indexed microengine state file (top).
// Holds program counter, condition bits, return link, memory data word and
// scratch word for each task. The selector's choice is broadcast as
// next_task one cycle early, every bank reads at that address, and the
// running task's state is written back from the upd_* inputs every cycle.
// Assumes the datapath presents valid upd_* values in every cycle.
module task_state_file
    import tsf_pkg::*;
#(
    parameter int NTASK = 16,
    parameter int PCW   = 12,
    parameter int CW    = 4,
    parameter int DW    = 16,
    localparam int TW = $clog2(NTASK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTASK-1:0] wake_req,
    input  logic             task_block,
    input  logic [PCW-1:0]   upd_pc,
    input  logic [CW-1:0]    upd_cond,
    input  logic [PCW-1:0]   upd_link,
    input  logic [DW-1:0]    upd_mdr,
    input  logic [DW-1:0]    upd_tmp,
    output logic [TW-1:0]    next_task,
    output logic [TW-1:0]    cur_task,
    output logic [PCW-1:0]   cur_pc,
    output logic [CW-1:0]    cur_cond,
    output logic [PCW-1:0]   cur_link,
    output logic [DW-1:0]    cur_mdr,
    output logic [DW-1:0]    cur_tmp
);
    tsf_arbiter #(.NTASK(NTASK)) u_arb (
        .req       (wake_req),
        .blk       (task_block),
        .cur_task  (cur_task),
        .next_task (next_task)
    );

    // Running-task register: follows the broadcast by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_task <= '0;
        else        cur_task <= next_task;
    end

    tsf_bank #(.NTASK(NTASK), .W(PCW), .INIT(INIT_INDEX)) u_pc (
        .clk(clk), .rst_n(rst_n), .rd_idx(next_task), .wr_idx(cur_task),
        .wr_data(upd_pc), .rd_q(cur_pc)
    );
    tsf_bank #(.NTASK(NTASK), .W(CW), .INIT(INIT_ZERO)) u_cond (
        .clk(clk), .rst_n(rst_n), .rd_idx(next_task), .wr_idx(cur_task),
        .wr_data(upd_cond), .rd_q(cur_cond)
    );
    tsf_bank #(.NTASK(NTASK), .W(PCW), .INIT(INIT_ZERO)) u_link (
        .clk(clk), .rst_n(rst_n), .rd_idx(next_task), .wr_idx(cur_task),
        .wr_data(upd_link), .rd_q(cur_link)
    );
    tsf_bank #(.NTASK(NTASK), .W(DW), .INIT(INIT_ZERO)) u_mdr (
        .clk(clk), .rst_n(rst_n), .rd_idx(next_task), .wr_idx(cur_task),
        .wr_data(upd_mdr), .rd_q(cur_mdr)
    );
    tsf_bank #(.NTASK(NTASK), .W(DW), .INIT(INIT_ZERO)) u_tmp (
        .clk(clk), .rst_n(rst_n), .rd_idx(next_task), .wr_idx(cur_task),
        .wr_data(upd_tmp), .rd_q(cur_tmp)
    );

    // Requests that can win; bit 0 forced low.
    logic [NTASK-1:0] req_live;
    assign req_live = {wake_req[NTASK-1:1], 1'b0};

    // R4: a foreground task that does not block keeps the engine.
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_task != '0 && !task_block) |=> (cur_task == $past(cur_task)));

    // R3: with a switch allowed and requests pending, winner is the top one.
    assert_prio_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((task_block || cur_task == '0) && req_live != '0)
            |-> ((req_live >> next_task) == NTASK'(1)));

    // R3, R9: with a switch allowed and nothing live pending, task 0 runs.
    assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((task_block || cur_task == '0) && req_live == '0)
            |=> (cur_task == '0));

    // R8: reselecting the running task presents its just-written state.
    assert_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (next_task == cur_task)
            |=> (cur_pc == $past(upd_pc) && cur_tmp == $past(upd_tmp)));
endmodule

// File: tb/task_state_file_tb.sv
`timescale 1ns/1ps
module task_state_file_tb;
    localparam int NTASK = 16;
    localparam int PCW   = 12;
    localparam int CW    = 4;
    localparam int DW    = 16;
    localparam int TW    = $clog2(NTASK);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NTASK-1:0] wake_req = '0;
    logic             task_block = 1'b0;
    logic [PCW-1:0]   upd_pc = '0;
    logic [CW-1:0]    upd_cond = '0;
    logic [PCW-1:0]   upd_link = '0;
    logic [DW-1:0]    upd_mdr = '0;
    logic [DW-1:0]    upd_tmp = '0;
    logic [TW-1:0]    next_task, cur_task;
    logic [PCW-1:0]   cur_pc, cur_link;
    logic [CW-1:0]    cur_cond;
    logic [DW-1:0]    cur_mdr, cur_tmp;

    task_state_file #(.NTASK(NTASK), .PCW(PCW), .CW(CW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .task_block(task_block),
        .upd_pc(upd_pc), .upd_cond(upd_cond), .upd_link(upd_link),
        .upd_mdr(upd_mdr), .upd_tmp(upd_tmp), .next_task(next_task),
        .cur_task(cur_task), .cur_pc(cur_pc), .cur_cond(cur_cond),
        .cur_link(cur_link), .cur_mdr(cur_mdr), .cur_tmp(cur_tmp)
    );

    always #4 clk = ~clk;  // 125 MHz

    typedef struct packed {
        logic [TW-1:0]  tsk;
        logic [PCW-1:0] pc;
        logic [CW-1:0]  cond;
        logic [PCW-1:0] link;
        logic [DW-1:0]  mdr;
        logic [DW-1:0]  tmp;
    } item_t;

    item_t exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    // Reference model of the stored state and the running task.
    logic [PCW-1:0] m_pc   [NTASK];
    logic [CW-1:0]  m_cond [NTASK];
    logic [PCW-1:0] m_link [NTASK];
    logic [DW-1:0]  m_mdr  [NTASK];
    logic [DW-1:0]  m_tmp  [NTASK];
    int             m_cur;

    function automatic int model_pick(logic [NTASK-1:0] r, logic b, int cur);
        if (!(b || cur == 0)) return cur;
        for (int k = NTASK - 1; k >= 1; k--) if (r[k]) return k;
        return 0;
    endfunction

    // Driver: apply one cycle of stimulus, check the broadcast, push expectation.
    task automatic step(input logic [NTASK-1:0] r, input logic b, input string tag);
        int nx;
        item_t it;
        wake_req   = r;
        task_block = b;
        upd_pc   = PCW'($urandom);
        upd_cond = CW'($urandom);
        upd_link = PCW'($urandom);
        upd_mdr  = DW'($urandom);
        upd_tmp  = DW'($urandom);
        #1;
        nx = model_pick(r, b, m_cur);
        checks++;
        if (next_task !== TW'(nx)) begin
            errors++;
            $display("FAIL %s next_task actual %0d expected %0d", tag, next_task, nx);
        end
        m_pc[m_cur]   = upd_pc;
        m_cond[m_cur] = upd_cond;
        m_link[m_cur] = upd_link;
        m_mdr[m_cur]  = upd_mdr;
        m_tmp[m_cur]  = upd_tmp;
        m_cur = nx;
        it.tsk  = TW'(nx);
        it.pc   = m_pc[nx];
        it.cond = m_cond[nx];
        it.link = m_link[nx];
        it.mdr  = m_mdr[nx];
        it.tmp  = m_tmp[nx];
        exp_q.push_back(it);
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    // Monitor: after each edge compare the presented task and state.
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            item_t e;
            item_t a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = '{cur_task, cur_pc, cur_cond, cur_link, cur_mdr, cur_tmp};
            checks++;
            if (a !== e) begin
                errors++;
                $display("FAIL %s (R2/R6) state actual task %0d pc %h cond %h link %h mdr %h tmp %h expected task %0d pc %h cond %h link %h mdr %h tmp %h",
                         t, a.tsk, a.pc, a.cond, a.link, a.mdr, a.tmp,
                         e.tsk, e.pc, e.cond, e.link, e.mdr, e.tmp);
            end
        end
    end

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NTASK; k++) begin
            m_pc[k] = PCW'(k); m_cond[k] = '0; m_link[k] = '0;
            m_mdr[k] = '0; m_tmp[k] = '0;
        end
        m_cur = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        checks++;
        if (cur_task !== '0 || cur_pc !== '0) begin
            errors++;
            $display("FAIL R1 reset actual task %0d pc %h expected task 0 pc 0", cur_task, cur_pc);
        end
        step('0, 1'b0, "R8 idle repeat");
        step('0, 1'b0, "R8 idle repeat");
        step(16'h0001, 1'b0, "R9 bit0 ignored");
        step(16'h0001, 1'b1, "R9 bit0 ignored");
        step(16'h0220, 1'b0, "R5 R1 preempt background");
        step(16'h1220, 1'b0, "R4 hold");
        step(16'h1220, 1'b0, "R4 hold");
        step(16'h1020, 1'b1, "R3 R1 switch");
        step(16'h0020, 1'b1, "R3 R1 switch");
        step(16'h0000, 1'b1, "R6 back to background");
        step(16'h0200, 1'b0, "R6 R7 revisit");
        step(16'h0220, 1'b1, "R8 reselect");
        step(16'h0000, 1'b1, "R3 idle");
        step(16'h1000, 1'b0, "R6 R7 revisit");
        step(16'h0000, 1'b1, "R7 return");
        for (int i = 0; i < 400; i++) begin
            logic [NTASK-1:0] r;
            r = NTASK'($urandom & $urandom & $urandom);
            step(r, ($urandom % 3) == 0, "R3 R7 random");
        end
        done = 1;
        summary();
        $finish;
    end
endmodule